// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns a single asynchronous receive line into checked characters. It works from a 16x oversampling tick supplied by an external baud generator. It follows the same line-control settings a companion transmitter uses: a data length of five to eight bits, an optional parity bit checked as even, odd or a fixed constant, and one or two stop bits. Every character is kept together with its own framing, parity and break flags. Characters wait either in a 16-entry FIFO or in a single holding register, as chosen by the queue-enable input.

The receiver waits for a falling edge on the line and confirms the start bit half a bit later. It then samples each following bit at its midpoint. Only the first stop bit is examined. After it has been sampled the receiver is free to look for a new start, so a two-stop setting needs no configuration input here. Configuration is taken at the moment a start is detected and holds for the whole frame.

Stored characters leave through a valid/ready port. `rd_valid_o` is high whenever an entry is waiting, and the entry at the head stays unchanged until a cycle in which `rd_valid_o` and `rd_ready_i` are both high. In that cycle the entry is removed. No back-pressure reaches the serial line: a character that finds no free storage is dropped, and the overrun flag is raised.

Top module: `uart_frame_rx`

## Requirements
- R1: Word-length code 0, 1, 2 and 3 receives 5, 6, 7 and 8 data bits. The first bit on the line becomes bit 0 of `rd_data_o`, and the bits above the data length read as 0.
- R2: With parity disabled, no parity bit is expected, the stop bit directly follows the data, and `rd_parity_err_o` is 0.
- R3: With parity enabled and stick off, even mode (even=1) expects a parity bit equal to the XOR of the data bits, and odd mode (even=0) expects its inverse. A mismatch sets `rd_parity_err_o` for that character.
- R4: With parity enabled and stick on, the parity bit must be 1 when even=0 and 0 when even=1. Any other value sets `rd_parity_err_o`.
- R5: A low level at the first stop-bit midpoint sets `rd_frame_err_o`. Nothing after the first stop bit is checked, so a new start may follow it directly.
- R6: A low pulse that is high again at the start-bit midpoint (8 ticks after the edge) is discarded and stores nothing.
- R7: A frame whose data bits, parity bit (if enabled) and stop bit are all low is stored with `rd_break_o`=1, `rd_frame_err_o`=1 and data 0. Only one entry is stored per break, and the receiver waits for the line to return high before it looks for the next start.
- R8: With queue enable = 1, up to 16 characters are held in arrival order, and `full_o` rises only when the 16th is stored.
- R9: With queue enable = 0, storage holds one character, and `full_o` is 1 whenever it is occupied.
- R10: A character that completes while storage is full is discarded. `overrun_o` is set, and it clears on the next accepted read.
- R11: `rd_valid_o` equals NOT `empty_o`. While `rd_valid_o` is high and `rd_ready_i` is low, the head entry's data and flags hold steady.
- R12: After reset `empty_o`=1, `full_o`=0, `rd_valid_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_wlen_i | input | 2 | Data length code: 0..3 gives 5..8 bits |
| cfg_par_en_i | input | 1 | A parity bit is present and checked |
| cfg_even_i | input | 1 | Even parity select (inverts the stick constant) |
| cfg_stick_i | input | 1 | Fixed-value parity select |
| cfg_fifo_en_i | input | 1 | 1: 16-entry queue, 0: one-entry holding register |
| rd_valid_o | output | 1 | A character is waiting |
| rd_ready_i | input | 1 | Consumer accepts the head character |
| rd_data_o | output | 8 | Head character data, zero-extended |
| rd_frame_err_o | output | 1 | Head character had a low stop bit |
| rd_parity_err_o | output | 1 | Head character failed its parity check |
| rd_break_o | output | 1 | Head character is a break |
| overrun_o | output | 1 | A character was dropped for lack of space |
| empty_o | output | 1 | No character stored |
| full_o | output | 1 | Storage at its current capacity |

## Verification
The bound checker watches the output port every cycle. It checks that valid and empty agree, that the head entry holds still under back-pressure, that a break entry always carries a framing error and zero data, that empty and full are never both set, that the holding-register mode reports full when occupied, and that an overrun only appears after a full cycle. The bench's scenarios are the only place where the contents of frames can be judged: the recovered bits for each data length, each parity mode, the framing error, glitch rejection, the single entry per break, queue ordering at its depth, and the drop on overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              frame_err;
    logic              parity_err;
    logic              brk;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[g] <= 1'b1;
        end else if (g == 0) begin
          chain[g] <= line_i;
        end else begin
          chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign line_o = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  input  logic       tick_i,
  input  logic [1:0] cfg_wlen_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_even_i,
  input  logic       cfg_stick_i,
  output logic       push_o,
  output rx_entry_t  entry_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_START = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] MID_BIT   = CW'(OSR - 1);

  rx_state_e          state;
  logic [CW-1:0]      cnt;
  logic [2:0]         bit_idx;
  logic [CHAR_W-1:0]  shreg;
  logic               par_bit;
  logic               armed;
  logic [1:0]         l_wlen;
  logic               l_par_en, l_even, l_stick;

  logic [2:0]         last_idx;
  logic [CHAR_W-1:0]  aligned;
  logic               exp_par;
  logic               at_mid;

  always_comb begin
    last_idx = {1'b0, l_wlen} + 3'd4;
    aligned  = shreg >> (~l_wlen);
    if (l_stick) exp_par = ~l_even;
    else if (l_even) exp_par = ^aligned;
    else exp_par = ~(^aligned);
    at_mid   = (cnt == MID_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      armed    <= 1'b0;
      l_wlen   <= 2'd3;
      l_par_en <= 1'b0;
      l_even   <= 1'b0;
      l_stick  <= 1'b0;
      push_o   <= 1'b0;
      entry_o  <= '0;
    end else begin
      push_o <= 1'b0;
      if (tick_i) begin
        unique case (state)
          ST_IDLE: begin
            if (line_i) begin
              armed <= 1'b1;
            end else if (armed) begin
              armed    <= 1'b0;
              state    <= ST_START;
              cnt      <= '0;
              l_wlen   <= cfg_wlen_i;
              l_par_en <= cfg_par_en_i;
              l_even   <= cfg_even_i;
              l_stick  <= cfg_stick_i;
            end
          end
          ST_START: begin
            if (cnt == MID_START) begin
              cnt <= '0;
              if (!line_i) begin
                state   <= ST_DATA;
                bit_idx <= '0;
                shreg   <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_mid) begin
              cnt     <= '0;
              shreg   <= {line_i, shreg[CHAR_W-1:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == last_idx) state <= l_par_en ? ST_PAR : ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_mid) begin
              cnt     <= '0;
              par_bit <= line_i;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_mid) begin
              cnt                <= '0;
              state              <= ST_IDLE;
              push_o             <= 1'b1;
              entry_o.data       <= aligned;
              entry_o.frame_err  <= ~line_i;
              entry_o.parity_err <= l_par_en && (par_bit != exp_par);
              entry_o.brk        <= ~line_i && (aligned == '0) && (!l_par_en || !par_bit);
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fifo_en_i,
  input  logic      push_i,
  input  rx_entry_t wr_entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic      overrun_o
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CAP_Q = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CAP_H = CNTW'(1);

  rx_entry_t        mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CNTW-1:0]  count;
  logic [CNTW-1:0]  cap;
  logic             pop_ok, accept;

  always_comb begin
    cap     = fifo_en_i ? CAP_Q : CAP_H;
    empty_o = (count == '0);
    full_o  = (count >= cap);
    pop_ok  = pop_i && !empty_o;
    accept  = push_i && (!full_o || pop_ok);
    head_o  = mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wr_entry_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (accept && !pop_ok) count <= count + 1'b1;
      else if (pop_ok && !accept) count <= count - 1'b1;
      if (push_i && !accept) overrun_o <= 1'b1;
      else if (pop_ok) overrun_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_i,
  input  logic       tick_i,
  input  logic [1:0] cfg_wlen_i,
  input  logic       cfg_par_en_i,
  input  logic       cfg_even_i,
  input  logic       cfg_stick_i,
  input  logic       cfg_fifo_en_i,
  output logic       rd_valid_o,
  input  logic       rd_ready_i,
  output logic [7:0] rd_data_o,
  output logic       rd_frame_err_o,
  output logic       rd_parity_err_o,
  output logic       rd_break_o,
  output logic       overrun_o,
  output logic       empty_o,
  output logic       full_o
);
  logic      line_s;
  logic      push;
  rx_entry_t entry, head;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_i(rx_i), .line_o(line_s)
  );

  uart_rx_framer #(.OSR(OSR)) u_framer (
    .clk(clk), .rst_n(rst_n), .line_i(line_s), .tick_i(tick_i),
    .cfg_wlen_i(cfg_wlen_i), .cfg_par_en_i(cfg_par_en_i),
    .cfg_even_i(cfg_even_i), .cfg_stick_i(cfg_stick_i),
    .push_o(push), .entry_o(entry)
  );

  uart_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(cfg_fifo_en_i),
    .push_i(push), .wr_entry_i(entry), .pop_i(rd_valid_o && rd_ready_i),
    .head_o(head), .empty_o(empty_o), .full_o(full_o), .overrun_o(overrun_o)
  );

  assign rd_valid_o      = ~empty_o;
  assign rd_data_o       = head.data;
  assign rd_frame_err_o  = head.frame_err;
  assign rd_parity_err_o = head.parity_err;
  assign rd_break_o      = head.brk;
endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_fifo_en_i,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic [7:0] rd_data_o,
  input logic       rd_frame_err_o,
  input logic       rd_parity_err_o,
  input logic       rd_break_o,
  input logic       overrun_o,
  input logic       empty_o,
  input logic       full_o
);
  p_valid_nonempty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o == !empty_o);

  p_head_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) &&
      $stable(rd_frame_err_o) && $stable(rd_parity_err_o) && $stable(rd_break_o));

  p_break_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && rd_break_o |-> rd_frame_err_o && rd_data_o == 8'd0);

  p_not_empty_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_o && full_o));

  p_hold_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en_i && !empty_o |-> full_o);

  p_overrun_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun_o) |-> $past(full_o));
endmodule

bind uart_frame_rx uart_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fifo_en_i(cfg_fifo_en_i),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o),
  .rd_frame_err_o(rd_frame_err_o), .rd_parity_err_o(rd_parity_err_o),
  .rd_break_o(rd_break_o), .overrun_o(overrun_o), .empty_o(empty_o),
  .full_o(full_o)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;
  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic tick = 1'b0;
  logic [1:0] wlen = 2'd3;
  logic par_en = 1'b0, even = 1'b0, stick = 1'b0, fifo_en = 1'b1;
  logic rd_ready = 1'b0;
  logic rd_valid, fe, pe, brk, ovr, empty, full;
  logic [7:0] rd_data;
  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  uart_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
    .cfg_wlen_i(wlen), .cfg_par_en_i(par_en), .cfg_even_i(even),
    .cfg_stick_i(stick), .cfg_fifo_en_i(fifo_en),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .rd_frame_err_o(fe), .rd_parity_err_o(pe), .rd_break_o(brk),
    .overrun_o(ovr), .empty_o(empty), .full_o(full)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic ev, input logic st);
    if (st) return ~ev;
    return ev ? ^d : ~(^d);
  endfunction

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic pbit, input logic stop_b, input int gap);
    int nb = int'(wlen) + 5;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) drive_bit(d[i]);
    if (par_en) drive_bit(pbit);
    drive_bit(stop_b);
    rx = 1'b1;
    repeat (gap * BITCLK) @(negedge clk);
  endtask

  task automatic pop_chk(input string req, input int d, input int f, input int p, input int b);
    chk(req, "valid", int'(rd_valid), 1);
    chk(req, "data", int'(rd_data), d);
    chk(req, "frame_err", int'(fe), f);
    chk(req, "parity_err", int'(pe), p);
    chk(req, "break", int'(brk), b);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R12", "empty", int'(empty), 1);
    chk("R12", "full", int'(full), 0);
    chk("R12", "valid", int'(rd_valid), 0);
    chk("R12", "overrun", int'(ovr), 0);
  endtask

  task automatic t_wlen();  // R1
    par_en = 0;
    for (int w = 0; w < 4; w++) begin
      wlen = 2'(w);
      send(8'hFF, 1'b0, 1'b1, 2);
      pop_chk("R1", (1 << (w + 5)) - 1, 0, 0, 0);
      send(8'hA6, 1'b0, 1'b1, 2);
      pop_chk("R1", 8'hA6 & ((1 << (w + 5)) - 1), 0, 0, 0);
    end
    wlen = 2'd3;
  endtask

  task automatic t_noparity();  // R2
    par_en = 0; even = 1; stick = 0;
    send(8'h3C, 1'b0, 1'b1, 2);
    pop_chk("R2", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_parity();  // R3
    par_en = 1; stick = 0;
    even = 1;
    send(8'h35, par_of(8'h35, 1, 0), 1'b1, 2);
    pop_chk("R3", 8'h35, 0, 0, 0);
    send(8'h35, ~par_of(8'h35, 1, 0), 1'b1, 2);
    pop_chk("R3", 8'h35, 0, 1, 0);
    even = 0;
    send(8'h81, par_of(8'h81, 0, 0), 1'b1, 2);
    pop_chk("R3", 8'h81, 0, 0, 0);
    send(8'h81, ~par_of(8'h81, 0, 0), 1'b1, 2);
    pop_chk("R3", 8'h81, 0, 1, 0);
    par_en = 0;
  endtask

  task automatic t_stick();  // R4
    par_en = 1; stick = 1;
    even = 0;
    send(8'h12, 1'b1, 1'b1, 2);
    pop_chk("R4", 8'h12, 0, 0, 0);
    send(8'h12, 1'b0, 1'b1, 2);
    pop_chk("R4", 8'h12, 0, 1, 0);
    even = 1;
    send(8'h7E, 1'b0, 1'b1, 2);
    pop_chk("R4", 8'h7E, 0, 0, 0);
    send(8'h7E, 1'b1, 1'b1, 2);
    pop_chk("R4", 8'h7E, 0, 1, 0);
    par_en = 0; stick = 0;
  endtask

  task automatic t_frame();  // R5
    send(8'h44, 1'b0, 1'b0, 2);
    pop_chk("R5", 8'h44, 1, 0, 0);
    send(8'h91, 1'b0, 1'b1, 0);
    send(8'h2B, 1'b0, 1'b1, 2);
    pop_chk("R5", 8'h91, 0, 0, 0);
    pop_chk("R5", 8'h2B, 0, 0, 0);
  endtask

  task automatic t_glitch();  // R6
    rx = 1'b0;
    repeat (6) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    chk("R6", "empty after glitch", int'(empty), 1);
    send(8'h5D, 1'b0, 1'b1, 2);
    pop_chk("R6", 8'h5D, 0, 0, 0);
  endtask

  task automatic t_break();  // R7
    rx = 1'b0;
    repeat (40 * BITCLK) @(negedge clk);
    rx = 1'b1;
    repeat (3 * BITCLK) @(negedge clk);
    pop_chk("R7", 0, 1, 0, 1);
    chk("R7", "single entry per break", int'(empty), 1);
    send(8'h66, 1'b0, 1'b1, 2);
    pop_chk("R7", 8'h66, 0, 0, 0);
  endtask

  task automatic t_fifo();  // R8, R10
    fifo_en = 1;
    for (int i = 0; i < 17; i++) begin
      send(8'(i * 17 + 3), 1'b0, 1'b1, 1);
      if (i == 14) chk("R8", "full after 15", int'(full), 0);
      if (i == 15) begin
        chk("R8", "full after 16", int'(full), 1);
        chk("R10", "no overrun yet", int'(ovr), 0);
      end
    end
    chk("R10", "overrun set", int'(ovr), 1);
    for (int i = 0; i < 16; i++) begin
      pop_chk("R8", (i * 17 + 3) & 8'hFF, 0, 0, 0);
      if (i == 0) chk("R10", "overrun cleared by read", int'(ovr), 0);
    end
    chk("R10", "dropped char absent", int'(empty), 1);
  endtask

  task automatic t_hold();  // R9, R10, R11
    fifo_en = 0;
    send(8'h5A, 1'b0, 1'b1, 2);
    chk("R9", "full with one", int'(full), 1);
    send(8'hC3, 1'b0, 1'b1, 2);
    chk("R10", "overrun in hold mode", int'(ovr), 1);
    chk("R11", "head held", int'(rd_data), 8'h5A);
    pop_chk("R9", 8'h5A, 0, 0, 0);
    chk("R9", "empty after read", int'(empty), 1);
    chk("R10", "overrun cleared", int'(ovr), 0);
    fifo_en = 1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    t_wlen();
    t_noparity();
    t_parity();
    t_stick();
    t_frame();
    t_glitch();
    t_break();
    t_fifo();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog (all R): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule